// File: doc/BRIEF.md
# Cache Control Register with Interrupt Freeze

This block is the 32-bit control and status register that a processor core uses to steer its instruction and data caches. Each cache has a 2-bit mode field: disabled, frozen or enabled. Each cache also has an enable bit that freezes it automatically when an interrupt is taken. The register also stores a burst-fetch enable and a snoop enable for later logic to use. It takes two write-only flush commands. Each command raises a pending flag that can be read back for a fixed number of cycles.

Software writes the register through a single-cycle write port. The current contents are always visible on the read bus. The core pulses `irq_taken` for one cycle when it accepts an interrupt. On that pulse, a cache whose freeze enable is set and whose mode is enabled drops to frozen. A cache in any other mode keeps its mode. If a write and an interrupt arrive in the same cycle, the written value is stored and the freeze is applied to it.

Top module: `cachectl_reg`

## Requirements
- R1: After reset the read bus shows all zeros, so both caches start disabled, with no freeze enables, no pending flushes, burst fetch off and snoop off.
- R2: A write stores bits [1:0] (instruction cache mode), [3:2] (data cache mode), 4 (instruction freeze enable), 5 (data freeze enable), 16 (burst fetch) and 23 (snoop). These bits read back unchanged on the next cycle. Every other bit reads zero apart from the two pending flags.
- R3: Mode encodings are 0 = disabled, 1 = frozen, 3 = enabled. When `irq_taken` is high, bit 4 is set and bits [1:0] equal 3, bits [1:0] become 1 on the next cycle.
- R4: When `irq_taken` is high, bit 5 is set and bits [3:2] equal 3, bits [3:2] become 1 on the next cycle.
- R5: When `irq_taken` is high and a cache's freeze enable is clear, that cache's mode field does not change.
- R6: On `irq_taken`, a cache mode of 0, 1 or the reserved value 2 is kept, even when that cache's freeze enable is set.
- R7: Writing 1 to bit 21 sets the instruction flush pending flag at bit 15. The flag reads 1 for exactly FLUSH_CYCLES cycles after the write and then clears by itself. Bit 21 always reads 0.
- R8: Writing 1 to bit 22 sets the data flush pending flag at bit 14 with the same FLUSH_CYCLES duration. Bit 22 always reads 0.
- R9: Writing 1 to bit 14 or bit 15 directly has no effect on the pending flags.
- R10: When a write and `irq_taken` arrive in the same cycle, the stored result is the written value with the freeze rule of R3 and R4 applied, using the freeze enables in the written value.
- R11: A flush command issued while that flag is already pending restarts the full FLUSH_CYCLES duration from the new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| irq_taken | input | 1 | One-cycle pulse when the core accepts an interrupt |
| rd_data | output | 32 | Current register contents |

## Verification
The assertions assume that `rst_n` is released on a clock edge. They also assume FLUSH_CYCLES is at least one, so a flush command is always visible for at least the cycle after it. Several properties hold only when no write happens in the observed cycle. Writes and interrupt pulses are therefore driven on the falling edge and held for exactly one cycle, and the bench leaves idle cycles between stimulus steps. The combined write-and-interrupt case is driven as one deliberate single cycle, so that it exercises the priority rule and no other property.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;

  localparam int unsigned REG_W = 32;

  // Field positions that software and the freeze logic depend on
  localparam int unsigned MODE_W       = 2;
  localparam int unsigned NUM_CACHES   = 2;   // index 0: instruction, 1: data
  localparam int unsigned MODE_LSB     = 0;   // cache i mode at [2i+1:2i]
  localparam int unsigned FRZ_EN_LSB   = 4;   // cache i freeze enable at 4+i
  localparam int unsigned PEND_D_BIT   = 14;
  localparam int unsigned PEND_I_BIT   = 15;
  localparam int unsigned BURST_BIT    = 16;
  localparam int unsigned FLUSH_I_BIT  = 21;
  localparam int unsigned FLUSH_D_BIT  = 22;
  localparam int unsigned SNOOP_BIT    = 23;

  typedef enum logic [MODE_W-1:0] {
    CMODE_OFF    = 2'd0,
    CMODE_FROZEN = 2'd1,
    CMODE_RSVD   = 2'd2,
    CMODE_ON     = 2'd3
  } cmode_e;

endpackage

// File: rtl/cachectl_freeze.sv
module cachectl_freeze
  import cachectl_pkg::*;
(
  input  logic              irq_taken,
  input  logic              freeze_en,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_out
);

  // Only an enabled cache drops to frozen; every other mode passes through
  always_comb begin
    mode_out = mode_in;
    if (irq_taken && freeze_en && (mode_in == CMODE_ON)) begin
      mode_out = CMODE_FROZEN;
    end
  end

endmodule

// File: rtl/cachectl_flush_timer.sv
module cachectl_flush_timer #(
  parameter int unsigned FLUSH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pending
);

  localparam int unsigned CNT_W = (FLUSH_CYCLES < 1) ? 1 : $clog2(FLUSH_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(FLUSH_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pending = (cnt_q != '0);

endmodule

// File: rtl/cachectl_reg.sv
module cachectl_reg
  import cachectl_pkg::*;
#(
  parameter int unsigned FLUSH_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_taken,
  output logic [REG_W-1:0] rd_data
);

  logic [MODE_W-1:0] mode_q   [NUM_CACHES];
  logic [MODE_W-1:0] mode_sel [NUM_CACHES];
  logic [MODE_W-1:0] mode_d   [NUM_CACHES];
  logic [NUM_CACHES-1:0] frz_en_q;
  logic [NUM_CACHES-1:0] frz_en_d;
  logic [NUM_CACHES-1:0] flush_start;
  logic [NUM_CACHES-1:0] flush_pend;
  logic burst_q, burst_d;
  logic snoop_q, snoop_d;
  logic fields_en;

  assign fields_en = wr_en || irq_taken;

  // Write data wins, then the freeze rule is applied to the selected value
  for (genvar gi = 0; gi < NUM_CACHES; gi++) begin : g_cache
    assign mode_sel[gi] = wr_en ? wr_data[MODE_LSB + MODE_W*gi +: MODE_W] : mode_q[gi];
    assign frz_en_d[gi] = wr_en ? wr_data[FRZ_EN_LSB + gi] : frz_en_q[gi];

    cachectl_freeze u_freeze (
      .irq_taken (irq_taken),
      .freeze_en (frz_en_d[gi]),
      .mode_in   (mode_sel[gi]),
      .mode_out  (mode_d[gi])
    );

    cachectl_flush_timer #(
      .FLUSH_CYCLES (FLUSH_CYCLES)
    ) u_flush (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (flush_start[gi]),
      .pending (flush_pend[gi])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[gi] <= '0;
      end else if (fields_en) begin
        mode_q[gi] <= mode_d[gi];
      end
    end
  end

  assign flush_start[0] = wr_en && wr_data[FLUSH_I_BIT];
  assign flush_start[1] = wr_en && wr_data[FLUSH_D_BIT];

  always_comb begin
    burst_d = wr_en ? wr_data[BURST_BIT] : burst_q;
    snoop_d = wr_en ? wr_data[SNOOP_BIT] : snoop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_en_q <= '0;
      burst_q  <= 1'b0;
      snoop_q  <= 1'b0;
    end else if (wr_en) begin
      frz_en_q <= frz_en_d;
      burst_q  <= burst_d;
      snoop_q  <= snoop_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CACHES; i++) begin
      rd_data[MODE_LSB + MODE_W*i +: MODE_W] = mode_q[i];
      rd_data[FRZ_EN_LSB + i]                = frz_en_q[i];
    end
    rd_data[PEND_I_BIT] = flush_pend[0];
    rd_data[PEND_D_BIT] = flush_pend[1];
    rd_data[BURST_BIT]  = burst_q;
    rd_data[SNOOP_BIT]  = snoop_q;
  end

  wire unused_wr_bits = ^{wr_data[REG_W-1:SNOOP_BIT+1], wr_data[20:BURST_BIT+1],
                          wr_data[PEND_I_BIT:FRZ_EN_LSB+NUM_CACHES]};

endmodule

// File: rtl/cachectl_reg_chk.sv
module cachectl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        irq_taken,
  input logic [31:0] rd_data
);

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFF7E_3FC0) == 32'h0); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !irq_taken) |=> (rd_data & 32'h0081_003F) == $past(rd_data & 32'h0081_003F)); // R2

  AST_I_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !wr_en && rd_data[4] && rd_data[1:0] == 2'd3) |=> rd_data[1:0] == 2'd1); // R3

  AST_D_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !wr_en && rd_data[5] && rd_data[3:2] == 2'd3) |=> rd_data[3:2] == 2'd1); // R4

  AST_I_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !wr_en && !rd_data[4]) |=> rd_data[1:0] == $past(rd_data[1:0])); // R5

  AST_D_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !wr_en && rd_data[3:2] != 2'd3) |=> rd_data[3:2] == $past(rd_data[3:2])); // R6

  AST_I_FLUSH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[21]) |=> rd_data[15]); // R7

  AST_D_FLUSH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[22]) |=> rd_data[14]); // R8

  AST_PEND_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[15] && !(wr_en && wr_data[21])) |=> !rd_data[15]); // R9

  AST_WRITE_THEN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && irq_taken && wr_data[4] && wr_data[1:0] == 2'd3) |=> rd_data[1:0] == 2'd1); // R10

endmodule

bind cachectl_reg cachectl_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .irq_taken (irq_taken),
  .rd_data   (rd_data)
);

// File: tb/tb_cachectl_reg.sv
module tb_cachectl_reg;

  localparam int unsigned FC = 8;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        irq_taken;
  logic [31:0] rd_data;

  int checks;
  int failures;
  bit finished;

  cachectl_reg #(.FLUSH_CYCLES(FC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_taken (irq_taken),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Drive on falling edge; after the next falling edge the result is visible
  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_irq();
    @(negedge clk);
    irq_taken = 1'b1;
    @(negedge clk);
    irq_taken = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 32'h0);
  endtask

  task automatic t_readback();
    do_write(32'hFFBF_3FFF & ~32'h0060_C000);
    check("R2 stored fields", rd_data, 32'h0081_003F);
    do_write(32'h0000_C000);
    check("R9 direct pending write ignored", rd_data, 32'h0);
  endtask

  task automatic t_ifreeze();
    do_write(32'h0001_0013);
    do_irq();
    check("R3 instruction freeze", rd_data, 32'h0001_0011);
  endtask

  task automatic t_dfreeze();
    do_write(32'h0080_002C);
    do_irq();
    check("R4 data freeze", rd_data, 32'h0080_0024);
  endtask

  task automatic t_no_enable();
    do_write(32'h0000_000F);
    do_irq();
    check("R5 freeze disabled", rd_data, 32'h0000_000F);
  endtask

  task automatic t_other_modes();
    do_write(32'h0000_0032);
    do_irq();
    check("R6 reserved and off kept", rd_data, 32'h0000_0032);
    do_write(32'h0000_0039);
    do_irq();
    check("R6 frozen and reserved kept", rd_data, 32'h0000_0039);
    do_write(32'h0000_0034);
    do_irq();
    check("R6 off and frozen kept", rd_data, 32'h0000_0034);
  endtask

  task automatic t_write_irq();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_003F; irq_taken = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; irq_taken = 1'b0;
    check("R10 write then freeze", rd_data, 32'h0000_0035);
  endtask

  task automatic t_flush_i();
    do_write(32'h0020_0000);
    check("R7 pending set, cmd reads 0", rd_data, 32'h0000_8000);
    idle(FC - 1);
    check("R7 pending at last cycle", rd_data, 32'h0000_8000);
    idle(1);
    check("R7 pending cleared", rd_data, 32'h0);
  endtask

  task automatic t_flush_d();
    do_write(32'h0040_0000);
    check("R8 pending set, cmd reads 0", rd_data, 32'h0000_4000);
    idle(FC - 1);
    check("R8 pending at last cycle", rd_data, 32'h0000_4000);
    idle(1);
    check("R8 pending cleared", rd_data, 32'h0);
  endtask

  task automatic t_flush_restart();
    do_write(32'h0020_0000);
    idle(3);
    do_write(32'h0020_0000);
    idle(FC - 1);
    check("R11 restarted pending held", rd_data, 32'h0000_8000);
    idle(1);
    check("R11 restarted pending cleared", rd_data, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    checks = 0; failures = 0; finished = 1'b0;
    wr_en = 1'b0; wr_data = '0; irq_taken = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_readback();
    idle(1);
    t_ifreeze();
    idle(1);
    t_dfreeze();
    idle(1);
    t_no_enable();
    idle(1);
    t_other_modes();
    idle(1);
    t_write_irq();
    idle(1);
    t_flush_i();
    idle(1);
    t_flush_d();
    idle(1);
    t_flush_restart();
    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule